// File: doc/BRIEF.md
# USB Charging Port Type Detector

This block works out what kind of USB port supplies power, once the session-valid indication goes high. It runs three timed stages against an analog detection front end. First it checks for data-pin contact, retrying up to a bounded number of polls. Then it runs a primary comparison that separates a standard downstream port from the charging ports. When that comparison succeeds, a secondary comparison separates a dedicated charger from a charging downstream port. Every dwell is counted in ticks of an external 1 ms strobe.

The sequencer drives five enables into the front end: detector power, transceiver non-driving mode, the contact current source, the primary source and the secondary source. It reads three comparator-style inputs through a two-stage synchronizer. When detection completes it reports:

- the port type and a done flag;
- an input-current budget in mA, with a one-cycle strobe that fires only when the value changes;
- a request to begin peripheral enumeration.

After that, a limit requested from the host side is applied only for a standard downstream port.

Top module: `chgdet_ctrl`

## Requirements
- R1: `det_state` reports the sequencer phase as 0 idle, 1 contact wait, 2 contact finished, 3 primary finished, 4 secondary finished, 5 detected.
- R2: `port_type` reads 0 none, 1 standard downstream, 2 dedicated charger, 3 charging downstream.
- R3: A rising edge of `sess_valid` while idle moves to state 1 on the next clock. It also raises `fe_block_on`, `fe_nondrive` and `fe_dcd_src`, clears the retry count and starts a `DCD_TICKS` tick dwell.
- R4: In state 1 the synchronized contact input is polled each time the dwell ends. Contact leaves the state. Otherwise the dwell restarts, unless this was poll number `DCD_MAX`, in which case the state is left anyway and no error results.
- R5: In state 2, `fe_prim_en` is high and `fe_dcd_src` is low. After `PRIM_TICKS` ticks the primary input is sampled. A low input gives type 1 and state 5.
- R6: A high primary input moves to state 3 with `fe_sec_en` high. After `SEC_TICKS` ticks the block goes to state 4, with type 2 if the secondary input is high and type 3 if it is low. It moves on to state 5 one clock later.
- R7: In state 5 all front-end enables are low. The current becomes `CHG_MA` (1500) for types 2 and 3, or `SDP_MA` (100) for type 1. `enum_req` is high for types 1 and 3 only.
- R8: When `sess_valid` is low, the next clock gives state 0, type 0, all enables low, `cur_ma` equal to 0 and `det_done` low.
- R9: `cur_ma` changes only together with a one-cycle `cur_ma_upd` pulse, and a request for the value already held gives no pulse.
- R10: A `host_ma_valid` request loads `host_ma` into `cur_ma` only in state 5 with type 1. In any other state or type it leaves `cur_ma` unchanged.
- R11: `contact_raw`, `prim_cmp_raw` and `sec_cmp_raw` reach the sequencer through two register stages.
- R12: `det_done` and `port_type` hold while `sess_valid` stays high. A new detection needs a fresh rising edge of `sess_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle 1 ms strobe |
| sess_valid | input | 1 | VBUS session valid |
| contact_raw | input | 1 | Data contact comparator, asynchronous |
| prim_cmp_raw | input | 1 | Primary detection comparator, asynchronous |
| sec_cmp_raw | input | 1 | Secondary detection comparator, asynchronous |
| host_ma_valid | input | 1 | Host-side current limit request strobe |
| host_ma | input | MA_W | Requested current limit in mA |
| fe_block_on | output | 1 | Detection block power |
| fe_nondrive | output | 1 | Transceiver non-driving mode |
| fe_dcd_src | output | 1 | Contact-detect current source enable |
| fe_prim_en | output | 1 | Primary detection enable |
| fe_sec_en | output | 1 | Secondary detection enable |
| det_state | output | 3 | Sequencer phase code |
| port_type | output | 2 | Detected port type code |
| det_done | output | 1 | Detection finished |
| cur_ma | output | MA_W | Allowed input current in mA |
| cur_ma_upd | output | 1 | Current value changed this cycle |
| enum_req | output | 1 | Request to start peripheral enumeration |

## Verification
The contact-wait timeout is the hardest path to reach from the ports: contact must stay low through every poll. The stimulus therefore holds `contact_raw` low for the whole wait, so the exit happens exactly on the final permitted poll, and it also checks a late contact that arrives just before an intermediate poll. Other runs take away `sess_valid` in the middle of the primary and secondary dwells. They also issue host limit requests before detection and for a charger type, and repeat the same limit to confirm that no change strobe results.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_CONTACT    = 3'd1,
        ST_CONTACT_OK = 3'd2,
        ST_PRIM_OK    = 3'd3,
        ST_SEC_OK     = 3'd4,
        ST_FOUND      = 3'd5
    } det_state_e;

    typedef enum logic [1:0] {
        PT_NONE = 2'd0,
        PT_SDP  = 2'd1,
        PT_DCP  = 2'd2,
        PT_CDP  = 2'd3
    } port_type_e;

    typedef struct packed {
        logic block_on;
        logic nondrive;
        logic dcd_src;
        logic prim_en;
        logic sec_en;
    } fe_ctrl_t;

    // Front-end enables implied by each phase of the sequence.
    function automatic fe_ctrl_t fe_for_state(det_state_e s);
        fe_ctrl_t f;
        f = '0;
        f.block_on = (s == ST_CONTACT) || (s == ST_CONTACT_OK) ||
                     (s == ST_PRIM_OK) || (s == ST_SEC_OK);
        f.nondrive = f.block_on;
        f.dcd_src  = (s == ST_CONTACT);
        f.prim_en  = (s == ST_CONTACT_OK);
        f.sec_en   = (s == ST_PRIM_OK);
        return f;
    endfunction

    function automatic logic wants_enum(port_type_e t);
        return (t == PT_SDP) || (t == PT_CDP);
    endfunction

endpackage

// File: rtl/chgdet_sync.sv
module chgdet_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= '0;
                else     stage[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= '0;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/chgdet_dwell.sv
module chgdet_dwell #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/chgdet_seq.sv
module chgdet_seq
    import chgdet_pkg::*;
#(
    parameter int DCD_TICKS  = 100,
    parameter int PRIM_TICKS = 40,
    parameter int SEC_TICKS  = 40,
    parameter int DCD_MAX    = 6,
    parameter int CW         = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sess_valid,
    input  logic          contact,
    input  logic          prim_hi,
    input  logic          sec_hi,
    input  logic          expired,
    output det_state_e    state,
    output port_type_e    ptype,
    output logic          load,
    output logic [CW-1:0] load_val
);
    localparam int RW = $clog2(DCD_MAX + 1);
    localparam logic [RW-1:0] LAST_POLL = RW'(DCD_MAX - 1);

    logic          sess_q;
    logic [RW-1:0] retries, retries_n;
    det_state_e    state_n;
    port_type_e    ptype_n;

    always_comb begin
        state_n   = state;
        ptype_n   = ptype;
        retries_n = retries;
        load      = 1'b0;
        load_val  = '0;
        if (!sess_valid) begin
            state_n   = ST_IDLE;
            ptype_n   = PT_NONE;
            retries_n = '0;
        end else begin
            unique case (state)
                ST_IDLE: if (!sess_q) begin
                    state_n   = ST_CONTACT;
                    retries_n = '0;
                    load      = 1'b1;
                    load_val  = CW'(DCD_TICKS);
                end
                ST_CONTACT: if (expired) begin
                    load = 1'b1;
                    if (contact || retries == LAST_POLL) begin
                        state_n  = ST_CONTACT_OK;
                        load_val = CW'(PRIM_TICKS);
                    end else begin
                        retries_n = retries + 1'b1;
                        load_val  = CW'(DCD_TICKS);
                    end
                end
                ST_CONTACT_OK: if (expired) begin
                    if (prim_hi) begin
                        state_n  = ST_PRIM_OK;
                        load     = 1'b1;
                        load_val = CW'(SEC_TICKS);
                    end else begin
                        state_n = ST_FOUND;
                        ptype_n = PT_SDP;
                    end
                end
                ST_PRIM_OK: if (expired) begin
                    state_n = ST_SEC_OK;
                    ptype_n = sec_hi ? PT_DCP : PT_CDP;
                end
                ST_SEC_OK: state_n = ST_FOUND;
                default:   state_n = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ptype   <= PT_NONE;
            retries <= '0;
            sess_q  <= 1'b0;
        end else begin
            state   <= state_n;
            ptype   <= ptype_n;
            retries <= retries_n;
            sess_q  <= sess_valid;
        end
    end
endmodule

// File: rtl/chgdet_limit.sv
module chgdet_limit #(
    parameter int MA_W = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [MA_W-1:0] req_ma,
    output logic [MA_W-1:0] cur_ma,
    output logic            upd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ma <= '0;
            upd    <= 1'b0;
        end else if (req_valid && req_ma != cur_ma) begin
            cur_ma <= req_ma;
            upd    <= 1'b1;
        end else begin
            upd    <= 1'b0;
        end
    end
endmodule

// File: rtl/chgdet_ctrl.sv
module chgdet_ctrl
    import chgdet_pkg::*;
#(
    parameter int DCD_TICKS  = 100,
    parameter int PRIM_TICKS = 40,
    parameter int SEC_TICKS  = 40,
    parameter int DCD_MAX    = 6,
    parameter int MA_W       = 11,
    parameter int SDP_MA     = 100,
    parameter int CHG_MA     = 1500
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_ms,
    input  logic            sess_valid,
    input  logic            contact_raw,
    input  logic            prim_cmp_raw,
    input  logic            sec_cmp_raw,
    input  logic            host_ma_valid,
    input  logic [MA_W-1:0] host_ma,
    output logic            fe_block_on,
    output logic            fe_nondrive,
    output logic            fe_dcd_src,
    output logic            fe_prim_en,
    output logic            fe_sec_en,
    output logic [2:0]      det_state,
    output logic [1:0]      port_type,
    output logic            det_done,
    output logic [MA_W-1:0] cur_ma,
    output logic            cur_ma_upd,
    output logic            enum_req
);
    localparam int MAX_A  = (DCD_TICKS > PRIM_TICKS) ? DCD_TICKS : PRIM_TICKS;
    localparam int MAX_T  = (MAX_A > SEC_TICKS) ? MAX_A : SEC_TICKS;
    localparam int CW     = $clog2(MAX_T + 1);

    logic [2:0]      sync_q;
    logic            expired, load;
    logic [CW-1:0]   load_val;
    det_state_e      state;
    port_type_e      ptype;
    fe_ctrl_t        fe;
    logic            found_q, found_enter;
    logic            req_valid;
    logic [MA_W-1:0] req_ma;

    chgdet_sync #(.W(3), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst),
        .d({contact_raw, prim_cmp_raw, sec_cmp_raw}),
        .q(sync_q)
    );

    chgdet_dwell #(.CW(CW)) u_dwell (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .tick(tick_ms), .expired(expired)
    );

    chgdet_seq #(
        .DCD_TICKS(DCD_TICKS), .PRIM_TICKS(PRIM_TICKS), .SEC_TICKS(SEC_TICKS),
        .DCD_MAX(DCD_MAX), .CW(CW)
    ) u_seq (
        .clk(clk), .rst(rst), .sess_valid(sess_valid),
        .contact(sync_q[2]), .prim_hi(sync_q[1]), .sec_hi(sync_q[0]),
        .expired(expired), .state(state), .ptype(ptype),
        .load(load), .load_val(load_val)
    );

    always_ff @(posedge clk) begin
        if (rst) found_q <= 1'b0;
        else     found_q <= (state == ST_FOUND);
    end
    assign found_enter = (state == ST_FOUND) && !found_q;

    // Current request arbitration: abort, then detection default, then host.
    always_comb begin
        req_valid = 1'b0;
        req_ma    = '0;
        if (!sess_valid) begin
            req_valid = 1'b1;
        end else if (found_enter) begin
            req_valid = 1'b1;
            req_ma    = (ptype == PT_SDP) ? MA_W'(SDP_MA) : MA_W'(CHG_MA);
        end else if (host_ma_valid && state == ST_FOUND && ptype == PT_SDP) begin
            req_valid = 1'b1;
            req_ma    = host_ma;
        end
    end

    chgdet_limit #(.MA_W(MA_W)) u_limit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ma(req_ma),
        .cur_ma(cur_ma), .upd(cur_ma_upd)
    );

    assign fe          = fe_for_state(state);
    assign fe_block_on = fe.block_on;
    assign fe_nondrive = fe.nondrive;
    assign fe_dcd_src  = fe.dcd_src;
    assign fe_prim_en  = fe.prim_en;
    assign fe_sec_en   = fe.sec_en;
    assign det_state   = state;
    assign port_type   = ptype;
    assign det_done    = (state == ST_FOUND);
    assign enum_req    = det_done && wants_enum(ptype);
endmodule

// File: rtl/chgdet_ctrl_chk.sv
module chgdet_ctrl_chk #(
    parameter int MA_W = 11
) (
    input logic            clk,
    input logic            rst,
    input logic            sess_valid,
    input logic            fe_block_on,
    input logic            fe_nondrive,
    input logic            fe_dcd_src,
    input logic            fe_prim_en,
    input logic            fe_sec_en,
    input logic [2:0]      det_state,
    input logic [1:0]      port_type,
    input logic            det_done,
    input logic [MA_W-1:0] cur_ma,
    input logic            cur_ma_upd,
    input logic            enum_req
);
    a_r1_state_range: assert property (@(posedge clk) disable iff (rst)
        det_state <= 3'd5);

    a_r8_abort: assert property (@(posedge clk) disable iff (rst)
        !sess_valid |=> (det_state == 3'd0) && (port_type == 2'd0) &&
                        (cur_ma == '0) && !fe_block_on && !fe_dcd_src &&
                        !fe_prim_en && !fe_sec_en);

    a_r5_one_source: assert property (@(posedge clk) disable iff (rst)
        $countones({fe_dcd_src, fe_prim_en, fe_sec_en}) <= 1);

    a_r7_front_end_off: assert property (@(posedge clk) disable iff (rst)
        det_done |-> !fe_block_on && !fe_nondrive);

    a_r7_no_enum_dcp: assert property (@(posedge clk) disable iff (rst)
        enum_req |-> det_done && (port_type != 2'd2));

    a_r9_strobe_on_change: assert property (@(posedge clk) disable iff (rst)
        cur_ma_upd |-> cur_ma != $past(cur_ma));

    a_r12_done_hold: assert property (@(posedge clk) disable iff (rst)
        det_done && sess_valid |=> det_done && $stable(port_type));
endmodule

bind chgdet_ctrl chgdet_ctrl_chk #(.MA_W(MA_W)) u_chk (
    .clk(clk), .rst(rst), .sess_valid(sess_valid),
    .fe_block_on(fe_block_on), .fe_nondrive(fe_nondrive),
    .fe_dcd_src(fe_dcd_src), .fe_prim_en(fe_prim_en), .fe_sec_en(fe_sec_en),
    .det_state(det_state), .port_type(port_type), .det_done(det_done),
    .cur_ma(cur_ma), .cur_ma_upd(cur_ma_upd), .enum_req(enum_req)
);

// File: tb/chgdet_ctrl_bench.sv
module chgdet_ctrl_bench;
    localparam int DT   = 5;
    localparam int PT   = 3;
    localparam int ST   = 3;
    localparam int DMAX = 6;
    localparam int MW   = 11;
    localparam int TDIV = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_ms = 1'b0;
    logic sess_valid = 1'b0, contact_raw = 1'b0, prim_cmp_raw = 1'b0, sec_cmp_raw = 1'b0;
    logic host_ma_valid = 1'b0;
    logic [MW-1:0] host_ma = '0;
    logic fe_block_on, fe_nondrive, fe_dcd_src, fe_prim_en, fe_sec_en;
    logic [2:0] det_state;
    logic [1:0] port_type;
    logic det_done, cur_ma_upd, enum_req;
    logic [MW-1:0] cur_ma;

    int n_chk = 0, n_bad = 0, cyc = 0, tdiv = 0;

    always #10 clk = ~clk;

    chgdet_ctrl #(.DCD_TICKS(DT), .PRIM_TICKS(PT), .SEC_TICKS(ST),
                  .DCD_MAX(DMAX), .MA_W(MW)) u_chgdet_ctrl (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .sess_valid(sess_valid),
        .contact_raw(contact_raw), .prim_cmp_raw(prim_cmp_raw),
        .sec_cmp_raw(sec_cmp_raw), .host_ma_valid(host_ma_valid),
        .host_ma(host_ma), .fe_block_on(fe_block_on), .fe_nondrive(fe_nondrive),
        .fe_dcd_src(fe_dcd_src), .fe_prim_en(fe_prim_en), .fe_sec_en(fe_sec_en),
        .det_state(det_state), .port_type(port_type), .det_done(det_done),
        .cur_ma(cur_ma), .cur_ma_upd(cur_ma_upd), .enum_req(enum_req)
    );

    task automatic check(int act, int exp, string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // Behavioural reference: state codes, type codes and mA values from the requirements.
    int m_state = 0, m_type = 0, m_polls = 0, m_wait = 0, m_ma = 0, m_upd = 0;
    int m_seen_sess = 0, m_was_found = 0;
    int qc[$], qp[$], qs[$];

    always @(posedge clk) begin : model
        int c, p, s, ns, nt, np, nw, req, rv;
        if (rst) begin
            m_state = 0; m_type = 0; m_polls = 0; m_wait = 0; m_ma = 0; m_upd = 0;
            m_seen_sess = 0; m_was_found = 0;
            qc = '{0, 0}; qp = '{0, 0}; qs = '{0, 0};
        end else begin
            c = qc[0]; p = qp[0]; s = qs[0];           // R11: two-cycle delay
            void'(qc.pop_front()); qc.push_back(int'(contact_raw));
            void'(qp.pop_front()); qp.push_back(int'(prim_cmp_raw));
            void'(qs.pop_front()); qs.push_back(int'(sec_cmp_raw));
            ns = m_state; nt = m_type; np = m_polls;
            nw = (tick_ms && m_wait > 0) ? m_wait - 1 : m_wait;
            rv = 0; req = 0;
            if (!sess_valid) rv = 1;
            else if (m_state == 5 && !m_was_found) begin
                rv = 1; req = (m_type == 1) ? 100 : 1500;
            end else if (host_ma_valid && m_state == 5 && m_type == 1) begin
                rv = 1; req = int'(host_ma);
            end
            if (!sess_valid) begin
                ns = 0; nt = 0; np = 0;
            end else if (m_state == 0) begin
                if (!m_seen_sess) begin ns = 1; np = 0; nw = DT; end
            end else if (m_state == 1) begin
                if (m_wait == 0) begin
                    if (c == 1 || m_polls + 1 == DMAX) begin ns = 2; nw = PT; end
                    else begin np = m_polls + 1; nw = DT; end
                end
            end else if (m_state == 2) begin
                if (m_wait == 0) begin
                    if (p == 1) begin ns = 3; nw = ST; end
                    else begin ns = 5; nt = 1; end
                end
            end else if (m_state == 3) begin
                if (m_wait == 0) begin ns = 4; nt = s ? 2 : 3; end
            end else if (m_state == 4) ns = 5;
            m_was_found = (m_state == 5);
            m_seen_sess = int'(sess_valid);
            if (rv == 1 && req != m_ma) begin m_ma = req; m_upd = 1; end
            else m_upd = 0;
            m_state = ns; m_type = nt; m_polls = np; m_wait = nw;
        end
    end

    always @(negedge clk) begin
        cyc++;
        tdiv = (tdiv + 1) % TDIV;
        tick_ms <= (tdiv == 0);
        if (!rst) begin
            check(int'(det_state), m_state, "R1 state");
            check(int'(port_type), m_type, "R2 type");
            check(int'(fe_block_on), (m_state >= 1 && m_state <= 4), "R3 block_on");
            check(int'(fe_nondrive), (m_state >= 1 && m_state <= 4), "R3 nondrive");
            check(int'(fe_dcd_src), (m_state == 1), "R4 dcd_src");
            check(int'(fe_prim_en), (m_state == 2), "R5 prim_en");
            check(int'(fe_sec_en), (m_state == 3), "R6 sec_en");
            check(int'(det_done), (m_state == 5), "R12 done");
            check(int'(enum_req), (m_state == 5 && (m_type == 1 || m_type == 3)), "R7 enum");
            check(int'(cur_ma), m_ma, "R8 cur_ma");
            check(int'(cur_ma_upd), m_upd, "R9 upd");
        end
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_req(int ma);
        @(negedge clk); host_ma <= MW'(ma); host_ma_valid <= 1'b1;
        @(negedge clk); host_ma_valid <= 1'b0;
    endtask

    task automatic session(bit cont, bit prim, bit sec);
        contact_raw <= cont; prim_cmp_raw <= prim; sec_cmp_raw <= sec;
        @(negedge clk); sess_valid <= 1'b1;
        wait_n(2);
        check(int'(det_state), 1, "R3 entry state");
    endtask

    task automatic drop;
        @(negedge clk); sess_valid <= 1'b0;
        wait_n(2);
        check(int'(det_state), 0, "R8 aborted state");
        check(int'(cur_ma), 0, "R8 zero current");
    endtask

    initial begin
        wait_n(3);
        check(int'(det_state), 0, "R1 reset state");
        check(int'(cur_ma), 0, "R8 reset current");
        @(negedge clk); rst <= 1'b0;
        wait_n(3);

        // Standard port: early contact, primary low.
        host_req(700);
        check(int'(cur_ma), 0, "R10 pre-detect request ignored");
        session(1'b1, 1'b0, 1'b0);
        wait_n(60);
        check(int'(port_type), 1, "R5 SDP type");
        check(int'(cur_ma), 100, "R7 SDP 100mA");
        host_req(500);
        wait_n(1);
        check(int'(cur_ma), 500, "R10 SDP host limit");
        host_req(500);
        wait_n(1);
        check(int'(cur_ma_upd), 0, "R9 same value no strobe");
        wait_n(20);
        check(int'(det_done), 1, "R12 done held");
        drop();

        // Contact never seen: timeout path, dedicated charger.
        session(1'b0, 1'b1, 1'b1);
        wait_n(DT * TDIV * DMAX - 4);
        check(int'(det_state), 1, "R4 still polling before final poll");
        wait_n(60);
        check(int'(port_type), 2, "R6 DCP type");
        check(int'(cur_ma), 1500, "R7 DCP 1500mA");
        check(int'(enum_req), 0, "R7 DCP no enum");
        host_req(300);
        wait_n(1);
        check(int'(cur_ma), 1500, "R10 DCP request ignored");
        drop();

        // Late contact, charging downstream port.
        session(1'b0, 1'b1, 1'b0);
        wait_n(DT * TDIV * 2);
        contact_raw <= 1'b1;
        wait_n(60);
        check(int'(port_type), 3, "R6 CDP type");
        check(int'(enum_req), 1, "R7 CDP enum");
        drop();

        // Abort in the middle of primary and secondary dwells.
        session(1'b1, 1'b1, 1'b0);
        wait_n(DT * TDIV + 4);
        drop();
        session(1'b1, 1'b1, 1'b1);
        wait_n(DT * TDIV + PT * TDIV + 4);
        drop();

        // Contact glitches near polls.
        session(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); contact_raw <= (i % 7 == 3);
        end
        wait_n(80);
        check(int'(det_done), 1, "R11 finished after glitches");
        // Session stays high: no restart (R12).
        wait_n(30);
        check(int'(det_state), 5, "R12 no restart without new edge");
        drop();

        wait_n(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule